// File: doc/BRIEF.md
# Logarithmic 8-bit code converter

This block converts between 32-bit unsigned integers and a compact 8-bit logarithmic code. In the code, the upper four bits select a segment (the exponent e) and the lower four bits give a position inside that segment (the mantissa m). Segments get wider as e grows. Each segment starts at an accumulated base of ((1<<e)-1)*16, so the code spans 0 to 1015792 with a relative step that stays roughly constant. There are two independent paths. One expands a code into its value. The other compresses a value into the code, rounding toward zero.

The compressing path first counts leading zeros to estimate the exponent, as the bit position of the top one minus four, clamped to 15. It then corrects that estimate against the segment bases: it can step down while the value lies below the current base, and it can step up while the value reaches the next base. It then subtracts the base and shifts to obtain the mantissa. A value beyond the largest decodable value saturates to the all-ones code. Both paths are combinational. With the `REG_OUT` parameter set (the default), each path has an output register. It has an asynchronous active-low reset, and there is no handshake. Every input is taken on every clock edge, so a consumer cannot stall either path. A consumer that needs a result must sample it on the cycle that result is due.

Top module: `log8_codec`

## Requirements
- R1: A code holds its exponent in bits [7:4] and its mantissa in bits [3:0], and decodes to m*2^e + (2^e - 1)*16.
- R2: A code with exponent field 0 decodes to its mantissa value unchanged.
- R3: An input value below 16 encodes to the code equal to that value (exponent 0).
- R4: An input value from 16 up to 1015792 encodes to the largest code whose decoded value does not exceed the input, and that code has a nonzero exponent field.
- R5: An input value above 1015792 encodes to 0xFF.
- R6: For every one of the 256 codes, encoding the decoded value returns the original code.
- R7: Decoded values strictly increase with the code, from 0x00 to 0xFF.
- R8: The value 0 encodes to code 0x00, and code 0x00 decodes to 0.
- R9: With REG_OUT=1, both results appear at the first rising clock edge after their inputs are applied. While reset is low, both outputs are 0 whatever the inputs are.
- R10: The first value of each segment e encodes to mantissa 0 with exponent e. The value one below the next segment's start encodes to mantissa 15 with exponent e.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the output registers |
| rst_ni | input | 1 | Asynchronous active-low reset |
| dec_code_i | input | 8 | Code to expand |
| dec_value_o | output | 32 | Expanded value of dec_code_i |
| enc_value_i | input | 32 | Value to compress |
| enc_code_o | output | 8 | Compressed code of enc_value_i |

## Verification
With the default registered outputs, the results for both paths are due exactly one rising edge after the inputs change. The bench drives the inputs on a falling edge and compares both outputs against a behavioural model on the next falling edge, which is the half-cycle after the result is due, on every cycle of the run. During the round-trip sweep, each decoded value is fed back into the encoder on the cycle after it appears. The re-encoded code is therefore checked two cycles after the code that produced it, and the monotonic check compares successive decoded values one cycle apart.

// File: rtl/log8_pkg.sv
package log8_pkg;
  localparam int LOG8_EXP_W = 4;
  localparam int LOG8_MAN_W = 4;
  localparam int LOG8_VAL_W = 32;

  typedef struct packed {
    logic [LOG8_EXP_W-1:0] seg;
    logic [LOG8_MAN_W-1:0] pos;
  } log8_code_t;
endpackage

// File: rtl/log8_lzc.sv
module log8_lzc #(
  parameter int W    = 32,
  parameter int LZ_W = $clog2(W) + 1
) (
  input  logic [W-1:0]    word_i,
  output logic [LZ_W-1:0] zeros_o
);
  localparam int STAGES = $clog2(W);

  logic [W-1:0]    rest [STAGES+1];
  logic [LZ_W-1:0] cnt  [STAGES+1];

  assign rest[0] = word_i;
  assign cnt[0]  = LZ_W'(W);

  // binary search: each stage halves the window that may hold the top one
  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    localparam int SH = W >> (s + 1);
    logic [W-1:0] upper;
    assign upper       = rest[s] >> SH;
    assign rest[s+1]   = (upper != '0) ? upper : rest[s];
    assign cnt[s+1]    = (upper != '0) ? cnt[s] - LZ_W'(SH) : cnt[s];
  end

  // remaining word is 0 or 1; a zero input keeps the full width as count
  assign zeros_o = cnt[STAGES] - LZ_W'(rest[STAGES]);
endmodule

// File: rtl/log8_decoder.sv
module log8_decoder #(
  parameter int VAL_W = log8_pkg::LOG8_VAL_W,
  parameter int EXP_W = log8_pkg::LOG8_EXP_W,
  parameter int MAN_W = log8_pkg::LOG8_MAN_W
) (
  input  logic [EXP_W+MAN_W-1:0] code_i,
  output logic [VAL_W-1:0]       value_o
);
  localparam int CODE_W = EXP_W + MAN_W;

  logic [EXP_W-1:0] seg;
  logic [MAN_W-1:0] pos;
  logic [VAL_W-1:0] seg_base;
  logic [VAL_W-1:0] scaled;

  assign seg = code_i[CODE_W-1:MAN_W];
  assign pos = code_i[MAN_W-1:0];

  // base of segment e is (2^e - 1) steps of the first segment width
  assign seg_base = ((VAL_W'(1) << seg) - VAL_W'(1)) << MAN_W;
  assign scaled   = VAL_W'(pos) << seg;
  assign value_o  = scaled + seg_base;
endmodule

// File: rtl/log8_encoder.sv
module log8_encoder #(
  parameter int VAL_W    = log8_pkg::LOG8_VAL_W,
  parameter int EXP_W    = log8_pkg::LOG8_EXP_W,
  parameter int MAN_W    = log8_pkg::LOG8_MAN_W,
  parameter int DN_STEPS = 2,
  parameter int UP_STEPS = 2
) (
  input  logic [VAL_W-1:0]       value_i,
  output logic [EXP_W+MAN_W-1:0] code_o
);
  localparam int CODE_W  = EXP_W + MAN_W;
  localparam int LZ_W    = $clog2(VAL_W) + 1;
  localparam int EXP_TOP = (1 << EXP_W) - 1;
  localparam logic [VAL_W-1:0] SEG0 = VAL_W'(1) << MAN_W;
  localparam logic [EXP_W-1:0] EXP_MAX = '1;

  logic [LZ_W-1:0]  lz;
  int               guess;
  logic [EXP_W-1:0] e_est;
  logic [VAL_W-1:0] off_est;

  log8_lzc #(.W(VAL_W), .LZ_W(LZ_W)) u_lzc (
    .word_i (value_i),
    .zeros_o(lz)
  );

  // estimate: top-one position minus mantissa width, clamped
  always_comb begin
    guess = VAL_W - 1 - MAN_W - int'(lz);
    if (guess < 1)            e_est = '0;
    else if (guess > EXP_TOP) e_est = EXP_MAX;
    else                      e_est = EXP_W'(guess);
  end

  assign off_est = ((VAL_W'(1) << e_est) - VAL_W'(1)) << MAN_W;

  // downward correction chain
  logic [EXP_W-1:0] e_dn   [DN_STEPS+1];
  logic [VAL_W-1:0] off_dn [DN_STEPS+1];
  assign e_dn[0]   = e_est;
  assign off_dn[0] = off_est;

  for (genvar d = 0; d < DN_STEPS; d++) begin : g_down
    logic below;
    assign below       = (e_dn[d] != '0) && (value_i < off_dn[d]);
    assign e_dn[d+1]   = below ? e_dn[d] - EXP_W'(1) : e_dn[d];
    assign off_dn[d+1] = below ? (off_dn[d] - SEG0) >> 1 : off_dn[d];
  end

  // upward correction chain
  logic [EXP_W-1:0] e_up   [UP_STEPS+1];
  logic [VAL_W-1:0] off_up [UP_STEPS+1];
  assign e_up[0]   = e_dn[DN_STEPS];
  assign off_up[0] = off_dn[DN_STEPS];

  for (genvar u = 0; u < UP_STEPS; u++) begin : g_up
    logic [VAL_W-1:0] nxt;
    logic             above;
    assign nxt         = (off_up[u] << 1) + SEG0;
    assign above       = (e_up[u] != EXP_MAX) && (value_i >= nxt);
    assign e_up[u+1]   = above ? e_up[u] + EXP_W'(1) : e_up[u];
    assign off_up[u+1] = above ? nxt : off_up[u];
  end

  logic [EXP_W-1:0] e_fin;
  logic [VAL_W-1:0] residue;
  logic [VAL_W-1:0] pos_full;
  logic             sat;

  assign e_fin    = e_up[UP_STEPS];
  assign residue  = value_i - off_up[UP_STEPS];
  assign pos_full = residue >> e_fin;
  assign sat      = (pos_full[VAL_W-1:MAN_W] != '0);

  always_comb begin
    if (sat) code_o = '1;
    else     code_o = CODE_W'({e_fin, pos_full[MAN_W-1:0]});
  end
endmodule

// File: rtl/log8_codec.sv
module log8_codec #(
  parameter int VAL_W   = log8_pkg::LOG8_VAL_W,
  parameter int EXP_W   = log8_pkg::LOG8_EXP_W,
  parameter int MAN_W   = log8_pkg::LOG8_MAN_W,
  parameter bit REG_OUT = 1'b1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [EXP_W+MAN_W-1:0] dec_code_i,
  output logic [VAL_W-1:0]       dec_value_o,
  input  logic [VAL_W-1:0]       enc_value_i,
  output logic [EXP_W+MAN_W-1:0] enc_code_o
);
  localparam int CODE_W = EXP_W + MAN_W;

  logic [VAL_W-1:0]  dec_comb;
  logic [CODE_W-1:0] enc_comb;

  log8_decoder #(.VAL_W(VAL_W), .EXP_W(EXP_W), .MAN_W(MAN_W)) u_dec (
    .code_i (dec_code_i),
    .value_o(dec_comb)
  );

  log8_encoder #(.VAL_W(VAL_W), .EXP_W(EXP_W), .MAN_W(MAN_W)) u_enc (
    .value_i(enc_value_i),
    .code_o (enc_comb)
  );

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        dec_value_o <= '0;
        enc_code_o  <= '0;
      end else begin
        dec_value_o <= dec_comb;
        enc_code_o  <= enc_comb;
      end
    end
  end else begin : g_comb
    assign dec_value_o = dec_comb;
    assign enc_code_o  = enc_comb;
  end
endmodule

// File: rtl/log8_codec_chk.sv
module log8_codec_chk #(
  parameter int VAL_W   = 32,
  parameter int EXP_W   = 4,
  parameter int MAN_W   = 4,
  parameter bit REG_OUT = 1'b1
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [EXP_W+MAN_W-1:0] dec_code_i,
  input logic [VAL_W-1:0]       dec_value_o,
  input logic [VAL_W-1:0]       enc_value_i,
  input logic [EXP_W+MAN_W-1:0] enc_code_o
);
  localparam int CODE_W = EXP_W + MAN_W;
  localparam longint EXP_TOP = (64'd1 << EXP_W) - 1;
  localparam longint MAN_TOP = (64'd1 << MAN_W) - 1;
  localparam longint TOP_VAL =
    (MAN_TOP << EXP_TOP) + (((64'd1 << EXP_TOP) - 1) << MAN_W);

  logic [CODE_W-1:0] code_seen;
  logic [VAL_W-1:0]  val_seen;
  logic              primed;

  if (REG_OUT) begin : g_lag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        code_seen <= '0;
        val_seen  <= '0;
        primed    <= 1'b0;
      end else begin
        code_seen <= dec_code_i;
        val_seen  <= enc_value_i;
        primed    <= 1'b1;
      end
    end
  end else begin : g_now
    assign code_seen = dec_code_i;
    assign val_seen  = enc_value_i;
    assign primed    = 1'b1;
  end

  assert_small_pass_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (primed && val_seen < VAL_W'(MAN_TOP + 1)) |-> enc_code_o == CODE_W'(val_seen));

  assert_saturate_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (primed && val_seen > VAL_W'(TOP_VAL)) |-> enc_code_o == '1);

  assert_seg_nonzero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (primed && val_seen > VAL_W'(MAN_TOP)) |-> enc_code_o[CODE_W-1:MAN_W] != '0);

  assert_first_seg_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (primed && code_seen[CODE_W-1:MAN_W] == '0)
      |-> dec_value_o == VAL_W'(code_seen[MAN_W-1:0]));

  assert_zero_code_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (primed && code_seen == '0) |-> dec_value_o == '0);
endmodule

bind log8_codec log8_codec_chk #(
  .VAL_W(VAL_W), .EXP_W(EXP_W), .MAN_W(MAN_W), .REG_OUT(REG_OUT)
) u_chk (.*);

// File: tb/log8_codec_bench.sv
`timescale 1ns/1ps
module log8_codec_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  dec_code_i = '0;
  logic [31:0] dec_value_o;
  logic [31:0] enc_value_i = '0;
  logic [7:0]  enc_code_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  log8_codec u_log8_codec (
    .clk_i, .rst_ni, .dec_code_i, .dec_value_o, .enc_value_i, .enc_code_o
  );

  // behavioural reference
  function automatic longint ref_dec(input int code);
    longint base = 0;
    int e = code / 16;
    int m = code % 16;
    for (int k = 0; k < e; k++) base = base * 2 + 16;
    return longint'(m) * (longint'(1) << e) + base;
  endfunction

  function automatic int ref_enc(input longint v);
    if (v > 1015792) return 255;
    for (int c = 255; c >= 0; c--) if (ref_dec(c) <= v) return c;
    return 0;
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one-deep expectation: result due one rising edge after drive
  bit          pend = 1'b0;
  longint      exp_dv;
  int          exp_ec;
  string       pend_tag;
  logic [31:0] obs_dv;
  logic [7:0]  obs_ec;

  task automatic step(input logic [7:0] c, input logic [31:0] v, input string tag,
                      input bit loop_back);
    @(negedge clk_i);
    obs_dv = dec_value_o;
    obs_ec = enc_code_o;
    if (pend) begin
      chk(longint'(obs_dv) == exp_dv, {pend_tag, " decode"}, obs_dv, exp_dv);
      chk(int'(obs_ec) == exp_ec, {pend_tag, " encode"}, obs_ec, exp_ec);
    end
    dec_code_i  = c;
    enc_value_i = loop_back ? obs_dv : v;
    exp_dv      = ref_dec(int'(c));
    exp_ec      = ref_enc(longint'(enc_value_i));
    pend_tag    = tag;
    pend        = 1'b1;
  endtask

  function automatic logic [31:0] seg_start(input int e);
    return 32'(ref_dec(e * 16));
  endfunction

  initial begin
    logic [31:0] lfsr = 32'h1d87_2b41;
    longint prev_dv = -1;

    // R9: reset holds both outputs at zero regardless of inputs
    dec_code_i  = 8'h5a;
    enc_value_i = 32'd777;
    repeat (3) @(negedge clk_i);
    chk(dec_value_o == 0, "R9 reset decode", dec_value_o, 0);
    chk(enc_code_o == 0, "R9 reset encode", enc_code_o, 0);
    rst_ni = 1'b1;

    // R8 zero, R3 small values, R2 first-segment codes
    step(8'h00, 32'd0, "R8 R9", 1'b0);
    for (int v = 0; v < 16; v++) step(8'(v), 32'(v), "R3 R2", 1'b0);

    // R10 segment edges, R1 decode of each segment's first and last code
    for (int e = 0; e < 16; e++) begin
      step(8'(e * 16), seg_start(e), "R10 R1 first", 1'b0);
      step(8'(e * 16 + 15), 32'(ref_dec(e * 16) + (longint'(16) << e) - 1),
           "R10 R1 last", 1'b0);
    end

    // R5 saturation around and far above the top
    step(8'hff, 32'd1015792, "R5 top", 1'b0);
    step(8'hfe, 32'd1015793, "R5 above", 1'b0);
    step(8'h7f, 32'd1048560, "R5 beyond", 1'b0);
    step(8'h80, 32'h0010_0000, "R5 pow", 1'b0);
    step(8'h81, 32'hffff_ffff, "R5 max", 1'b0);

    // R4 pseudo-random values of varied magnitude
    for (int i = 0; i < 120; i++) begin
      lfsr = lfsr ^ (lfsr << 13);
      lfsr = lfsr ^ (lfsr >> 17);
      lfsr = lfsr ^ (lfsr << 5);
      step(lfsr[31:24], lfsr >> (i % 24), "R4 R1", 1'b0);
    end

    // R6 R7 round trip sweep: decoded value fed straight back into encoder
    for (int k = 0; k < 258; k++) begin
      step(8'(k < 256 ? k : 0), 32'd0, "R6 R1", 1'b1);
      if (k >= 2 && k <= 257) begin
        chk(int'(obs_ec) == k - 2, "R6 round trip", obs_ec, k - 2);
      end
      if (k >= 1 && k <= 256) begin
        chk(longint'(obs_dv) > prev_dv, "R7 increasing", obs_dv, prev_dv + 1);
        prev_dv = longint'(obs_dv);
      end
    end
    step(8'h00, 32'd0, "R8 flush", 1'b0);
    step(8'h00, 32'd0, "R8 flush", 1'b0);

    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog R9 actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule